// File: doc/BRIEF.md
# Microprogram Sequencer with Encoded Jump Types

This block is the control engine of a microcoded processor. It keeps a 6-bit microprogram counter and uses it to address a control store. The store is computed in logic and stays fixed. Each control-store word has two parts: an 18-bit control word that drives the datapath for the current step, and a 3-bit jump type. Next-address logic decodes the jump type each cycle and picks the following step. The candidates are the incremented counter, the current counter (to wait for memory), the start of instruction fetch, or the first step of the routine chosen by the current opcode.

The datapath supplies three inputs. The opcode comes from the instruction register. The condition flag comes from the ALU comparison. The busy flag is high while memory has not completed. All three are plain level signals sampled on the rising clock edge, so the block has no handshake and no back-pressure. The control word depends only on the current counter value. The store holds these routines:

- fetch
- register-register ALU
- register-immediate ALU
- load word
- jump-and-link
- branch on a true condition
- branch on a false condition
- an illegal-opcode trap

Top module: `useq_top`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after release, `upc` is 0 (first fetch step). In that step the control word asserts `ma_ld` (bit 17) and `a_ld` (bit 16) with `reg_sel` (bits 10:9) = 0, which selects the PC.
- R2: A step whose jump type is "next" moves `upc` to `upc+1` on the next clock. Steps 0, 3, 4, 6, 7, 9, 10, 11, 14, 15, 16, 18, 19, 21, 22, 25, 26, 28 and 29 are "next" steps.
- R3: A step whose jump type is "spin" holds `upc` for every cycle in which `busy` is high. It moves to `upc+1` on the first clock with `busy` low. Steps 1 (instruction read) and 12 (load data) are spin steps.
- R4: A step whose jump type is "fetch" returns `upc` to 0. Steps 5, 8, 13, 17, 23, 24 and 30 are fetch steps, as is every address from 31 to 63.
- R5: Step 2 is a dispatch step. The next `upc` is chosen by `opcode`:
  - 0x0C goes to 3 (register ALU).
  - 0x04 goes to 6 (immediate ALU).
  - 0x00 goes to 9 (load word).
  - 0x1B goes to 14 (jump-and-link).
  - 0x18 goes to 18 (branch if condition true).
  - 0x19 goes to 25 (branch if condition false).
- R6: Any other opcode dispatches to step 24. Step 24 asserts `trap` (bit 0) and returns to step 0 on the next clock. `trap` is low in every step from 0 to 30 other than 24.
- R7: Step 20 has jump type "ffalse". It goes to 0 when `cond` is low and to 21 when `cond` is high. The taken path then runs 21, 22, 23 and returns to 0.
- R8: Step 27 has jump type "ftrue". It goes to 0 when `cond` is high and to 28 when `cond` is low. The taken path then runs 28, 29, 30 and returns to 0.
- R9: `ir_ld` (bit 14) is high only in step 1. `pc_ld` (bit 13) is high only in steps 2, 17, 23 and 30.
- R10: The control word is a function of `upc` alone. While `upc` is unchanged, `ctrl` is unchanged, whatever `opcode`, `cond` or `busy` do.
- R11: `reg_wr` (bit 11) is high only in steps 5, 8, 12 and 14, which are the register write-back steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 5 | Opcode group field from the instruction register |
| cond | input | 1 | Branch condition from the ALU comparison |
| busy | input | 1 | Memory still busy |
| upc | output | 6 | Current microprogram counter |
| ctrl | output | 18 | Control word for the current step |

## Verification
A wrong counter value appears on `upc` on the very next clock edge. It also appears on `ctrl` in the same cycle, because the control word is looked up directly from the counter. A mis-decoded jump type usually shows up in a single cycle, as one of three faults:

- a skipped wait on `busy`
- a missed return to fetch
- a dispatch to the wrong routine

A wrong control-store entry shows up as a wrong strobe in exactly the step it belongs to. The reference model predicts the counter every cycle under random `busy`, `cond` and `opcode`, so any of these faults is seen within the first instruction that reaches the faulty step.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int ADDR_W = 6;
  localparam int OP_W   = 5;

  typedef enum logic [2:0] {
    J_NEXT   = 3'd0,
    J_SPIN   = 3'd1,
    J_FETCH  = 3'd2,
    J_DISP   = 3'd3,
    J_FTRUE  = 3'd4,
    J_FFALSE = 3'd5
  } jump_t;

  localparam logic [1:0] SEL_PC  = 2'd0;
  localparam logic [1:0] SEL_RS1 = 2'd1;
  localparam logic [1:0] SEL_RS2 = 2'd2;
  localparam logic [1:0] SEL_RD  = 2'd3;

  localparam logic [1:0] IMM_I = 2'd0;
  localparam logic [1:0] IMM_B = 2'd1;
  localparam logic [1:0] IMM_J = 2'd2;

  localparam logic [1:0] OP_ADD  = 2'd0;
  localparam logic [1:0] OP_FUNC = 2'd1;
  localparam logic [1:0] OP_SUB4 = 2'd2;
  localparam logic [1:0] OP_ADD4 = 2'd3;

  typedef struct packed {
    logic       ma_ld;
    logic       a_ld;
    logic       b_ld;
    logic       ir_ld;
    logic       pc_ld;
    logic       reg_en;
    logic       reg_wr;
    logic [1:0] reg_sel;
    logic       imm_en;
    logic [1:0] imm_sel;
    logic       alu_en;
    logic [1:0] alu_op;
    logic       mem_en;
    logic       mem_wr;
    logic       trap;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // routine entry points
  localparam logic [ADDR_W-1:0] A_FETCH = 6'd0;
  localparam logic [ADDR_W-1:0] A_ALU   = 6'd3;
  localparam logic [ADDR_W-1:0] A_ALUI  = 6'd6;
  localparam logic [ADDR_W-1:0] A_LW    = 6'd9;
  localparam logic [ADDR_W-1:0] A_JAL   = 6'd14;
  localparam logic [ADDR_W-1:0] A_BT    = 6'd18;
  localparam logic [ADDR_W-1:0] A_ILL   = 6'd24;
  localparam logic [ADDR_W-1:0] A_BF    = 6'd25;

endpackage

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output ctrl_t             word,
  output jump_t             jt
);

  always_comb begin
    word = '0;
    jt   = J_NEXT;
    case (addr)
      // fetch
      6'd0: begin word.ma_ld = 1'b1; word.a_ld = 1'b1; word.reg_en = 1'b1; word.reg_sel = SEL_PC; end
      6'd1: begin word.ir_ld = 1'b1; word.mem_en = 1'b1; jt = J_SPIN; end
      6'd2: begin word.pc_ld = 1'b1; word.alu_en = 1'b1; word.alu_op = OP_ADD4; jt = J_DISP; end
      // register ALU, immediate ALU, load and both branches read rs1 first
      6'd3, 6'd6, 6'd9, 6'd18, 6'd25: begin
        word.a_ld = 1'b1; word.reg_en = 1'b1; word.reg_sel = SEL_RS1;
      end
      6'd4, 6'd19, 6'd26: begin
        word.b_ld = 1'b1; word.reg_en = 1'b1; word.reg_sel = SEL_RS2;
      end
      6'd7, 6'd10: begin
        word.b_ld = 1'b1; word.imm_en = 1'b1; word.imm_sel = IMM_I;
      end
      6'd5, 6'd8: begin
        word.reg_wr = 1'b1; word.reg_sel = SEL_RD; word.alu_en = 1'b1; word.alu_op = OP_FUNC;
        jt = J_FETCH;
      end
      // load word
      6'd11: begin word.ma_ld = 1'b1; word.alu_en = 1'b1; word.alu_op = OP_ADD; end
      6'd12: begin word.reg_wr = 1'b1; word.reg_sel = SEL_RD; word.mem_en = 1'b1; jt = J_SPIN; end
      6'd13: jt = J_FETCH;
      // jump-and-link
      6'd14: begin word.reg_wr = 1'b1; word.reg_sel = SEL_RD; end
      6'd15, 6'd21, 6'd28: begin word.a_ld = 1'b1; word.alu_en = 1'b1; word.alu_op = OP_SUB4; end
      6'd16: begin word.b_ld = 1'b1; word.imm_en = 1'b1; word.imm_sel = IMM_J; end
      6'd17, 6'd23, 6'd30: begin
        word.pc_ld = 1'b1; word.alu_en = 1'b1; word.alu_op = OP_ADD; jt = J_FETCH;
      end
      // branches: condition test while loading the PC into A
      6'd20: begin word.a_ld = 1'b1; word.reg_en = 1'b1; word.reg_sel = SEL_PC; jt = J_FFALSE; end
      6'd27: begin word.a_ld = 1'b1; word.reg_en = 1'b1; word.reg_sel = SEL_PC; jt = J_FTRUE; end
      6'd22, 6'd29: begin word.b_ld = 1'b1; word.imm_en = 1'b1; word.imm_sel = IMM_B; end
      // step 24 and every unused word: trap, back to fetch
      default: begin word.trap = 1'b1; jt = J_FETCH; end
    endcase
  end

endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
  import useq_pkg::*;
(
  input  logic [OP_W-1:0]   opcode,
  output logic [ADDR_W-1:0] target
);

  always_comb begin
    case (opcode)
      5'h0C:   target = A_ALU;
      5'h04:   target = A_ALUI;
      5'h00:   target = A_LW;
      5'h1B:   target = A_JAL;
      5'h18:   target = A_BT;
      5'h19:   target = A_BF;
      default: target = A_ILL;
    endcase
  end

endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
(
  input  logic [ADDR_W-1:0] cur,
  input  jump_t             jt,
  input  logic              busy,
  input  logic              cond,
  input  logic [ADDR_W-1:0] disp,
  output logic [ADDR_W-1:0] nxt
);

  logic [ADDR_W-1:0] inc;
  assign inc = cur + ADDR_W'(1);

  always_comb begin
    case (jt)
      J_NEXT:   nxt = inc;
      J_SPIN:   nxt = busy ? cur : inc;
      J_FETCH:  nxt = A_FETCH;
      J_DISP:   nxt = disp;
      J_FTRUE:  nxt = cond ? A_FETCH : inc;
      J_FFALSE: nxt = cond ? inc : A_FETCH;
      default:  nxt = A_FETCH;
    endcase
  end

endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [OP_W-1:0]     opcode,
  input  logic                cond,
  input  logic                busy,
  output logic [ADDR_W-1:0]   upc,
  output logic [CTRL_W-1:0]   ctrl
);

  ctrl_t             word;
  jump_t             jt;
  logic [ADDR_W-1:0] disp;
  logic [ADDR_W-1:0] nxt;

  useq_store u_store (
    .addr (upc),
    .word (word),
    .jt   (jt)
  );

  useq_dispatch u_disp (
    .opcode (opcode),
    .target (disp)
  );

  useq_next u_next (
    .cur  (upc),
    .jt   (jt),
    .busy (busy),
    .cond (cond),
    .disp (disp),
    .nxt  (nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upc <= A_FETCH;
    else        upc <= nxt;
  end

  assign ctrl = word;

endmodule

// File: rtl/useq_chk.sv
module useq_chk
  import useq_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                cond,
  input logic                busy,
  input logic [ADDR_W-1:0]   upc,
  input logic [CTRL_W-1:0]   ctrl,
  input jump_t               jt
);

  // R2
  next_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jt == J_NEXT |=> upc == ADDR_W'($past(upc) + ADDR_W'(1)));

  // R3
  spin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (jt == J_SPIN && busy) |=> $stable(upc));

  // R4
  fetch_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jt == J_FETCH |=> upc == A_FETCH);

  // R7
  ffalse_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (jt == J_FFALSE && !cond) |=> upc == A_FETCH);

  // R8
  ftrue_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (jt == J_FTRUE && cond) |=> upc == A_FETCH);

  // R10
  ctrl_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(upc) |-> $stable(ctrl));

endmodule

bind useq_top useq_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .cond  (cond),
  .busy  (busy),
  .upc   (upc),
  .ctrl  (ctrl),
  .jt    (jt)
);

// File: tb/useq_top_bench.sv
module useq_top_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] opcode;
  logic       cond;
  logic       busy;
  logic [5:0] upc;
  logic [17:0] ctrl;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  useq_top u_useq_top (
    .clk    (clk),
    .rst_n  (rst_n),
    .opcode (opcode),
    .cond   (cond),
    .busy   (busy),
    .upc    (upc),
    .ctrl   (ctrl)
  );

  // step kinds: 0 next, 1 spin, 2 to fetch, 3 dispatch, 4 exit-if-true, 5 exit-if-false
  function automatic int kind_of(int a);
    if (a == 1 || a == 12) return 1;
    if (a == 2) return 3;
    if (a == 20) return 5;
    if (a == 27) return 4;
    if (a == 5 || a == 8 || a == 13 || a == 17 || a == 23 || a == 24 || a >= 30) return 2;
    return 0;
  endfunction

  function automatic int entry_of(logic [4:0] op);
    case (op)
      5'h0C: return 3;
      5'h04: return 6;
      5'h00: return 9;
      5'h1B: return 14;
      5'h18: return 18;
      5'h19: return 25;
      default: return 24;
    endcase
  endfunction

  int    model;
  string tag;
  logic [15:0] lfsr = 16'hACE1;
  logic [4:0] ops [8] = '{5'h0C, 5'h04, 5'h00, 5'h1B, 5'h18, 5'h19, 5'h1F, 5'h01};

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive_and_predict();
    int k;
    for (int i = 0; i < 5; i++) lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    busy   = lfsr[0] | lfsr[1];
    cond   = lfsr[2];
    opcode = ops[lfsr[5:3]];
    k = kind_of(model);
    case (k)
      0: begin tag = "R2"; model = (model + 1) % 64; end
      1: begin tag = "R3"; if (!busy) model = model + 1; end
      2: begin tag = "R4"; model = 0; end
      3: begin model = entry_of(opcode); tag = (model == 24) ? "R6" : "R5"; end
      4: begin tag = "R8"; model = cond ? 0 : model + 1; end
      default: begin tag = "R7"; model = cond ? model + 1 : 0; end
    endcase
  endtask

  initial begin
    logic [5:0]  last_upc;
    logic [17:0] last_ctrl;
    rst_n = 1'b0; opcode = 5'h0C; cond = 1'b0; busy = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 upc", int'(upc), 0);
    check("R1 fetch0 strobes", int'({ctrl[17], ctrl[16], ctrl[10:9]}), 'b1100);
    model = 0;
    rst_n = 1'b1;
    last_upc = upc; last_ctrl = ctrl;
    drive_and_predict();
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      check(tag, int'(upc), model);
      check("R9 ir_ld", int'(ctrl[14]), int'(upc == 1));
      check("R9 pc_ld", int'(ctrl[13]), int'(upc == 2 || upc == 17 || upc == 23 || upc == 30));
      check("R11 reg_wr", int'(ctrl[11]), int'(upc == 5 || upc == 8 || upc == 12 || upc == 14));
      if (upc <= 30) check("R6 trap", int'(ctrl[0]), int'(upc == 24));
      if (upc == 0) check("R1 fetch0 strobes", int'({ctrl[17], ctrl[16], ctrl[10:9]}), 'b1100);
      if (upc == last_upc) check("R10 ctrl steady", int'(ctrl), int'(last_ctrl));
      last_upc = upc; last_ctrl = ctrl;
      drive_and_predict();
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule